// File: doc/BRIEF.md
# Serial Receive Deframer with Parity Check

This block turns an asynchronous serial line into completed characters. It watches the line for a falling edge while enabled, then confirms the start bit half a bit period later. If the start bit holds, it takes one sample from the middle of each following bit. The bit timing comes from an oversample tick that the surrounding logic supplies at a fixed multiple of the bit rate (16 by default). Character length runs from five to nine bits. An optional parity bit follows the data and is checked for odd or even parity. Only the first stop bit is examined.

When the first stop bit has been sampled, the block produces a one-cycle push strobe. With the strobe come the low data byte, a separate ninth bit, a frame-error flag and a parity-error flag, all meant for a downstream receive buffer. A separate pulse marks each confirmed start bit, so the buffer can decide whether an overrun has occurred. The character length and parity settings are captured when the start edge is seen, so each frame is decoded with the settings that were in force when it began. Deasserting the enable abandons any frame in progress.

Top module: `uart_rx_deframer`

## Requirements
- R1: A low level seen on an oversample tick only arms reception while `en_i` is high. If the line is back high at the mid-start sample (OVS/2 ticks later), the block returns to idle with no start pulse and no push.
- R2: `start_o` pulses for exactly one cycle each time a start bit is confirmed low at its middle.
- R3: Data bits are taken least significant first, one sample each, at the middle of each bit period (OVS ticks apart). For characters shorter than 8 bits, the unused upper bits of `data_o` are 0.
- R4: `size_i` selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8, and 4 to 7 give 9.
- R5: In 9-bit mode the last data bit appears on `bit9_o` and `data_o` holds bits 0 to 7. In all other modes `bit9_o` is 0.
- R6: With `par_en_i` set, one parity bit follows the data. `perr_o` is 1 when the ones among data bits plus parity bit are odd with `par_odd_i`=0 (even parity), or even with `par_odd_i`=1 (odd parity).
- R7: `perr_o` is 0 for every frame received while parity checking was disabled, and no parity bit is expected.
- R8: `ferr_o` is 1 when the first stop bit is sampled 0 and 0 when it is sampled 1. After a 0 stop bit, the block waits for the line to return high before arming again.
- R9: `push_o` is high for exactly one cycle per completed frame, at the middle of the first stop bit. Outputs hold between pushes. Any further stop bits are not checked, and a start bit directly after one stop bit is received.
- R10: Size and parity settings are captured at the start edge. Changing them during a frame does not affect that frame.
- R11: Dropping `en_i` abandons a frame in progress: no push follows for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Receiver enable |
| tick_i | input | 1 | Oversample tick, OVS per bit period |
| rxd_i | input | 1 | Serial line, idle high |
| size_i | input | 3 | Character length select |
| par_en_i | input | 1 | Parity check enable |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| start_o | output | 1 | Start bit confirmed pulse |
| push_o | output | 1 | Completed frame strobe |
| data_o | output | 8 | Received data, bits 0 to 7 |
| bit9_o | output | 1 | Ninth data bit |
| ferr_o | output | 1 | First stop bit was 0 |
| perr_o | output | 1 | Parity mismatch |

## Verification
The hardest situations to reach from the ports are the ones that depend on when things happen inside a frame. One is a configuration change made after the start edge has been accepted. Another is an enable drop partway through the data bits. The driver task handles both by changing the settings, or lowering the enable, on bit boundaries it counts itself, after it has already queued the expected result for the original settings or withheld it. A short low pulse on the line tests false-start rejection, and a frame whose stop bit is held low tests the wait for the line to go high again.

// File: rtl/urx_pkg.sv
package urx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_HOLD
   } urx_state_e;

   localparam int unsigned URX_MAX_BITS = 9;
   localparam int unsigned URX_CNT_W    = $clog2(URX_MAX_BITS + 1);

   function automatic logic [URX_CNT_W-1:0] urx_len(input logic [2:0] code);
      if (code >= 3'd4) return URX_CNT_W'(URX_MAX_BITS);
      return URX_CNT_W'(code) + URX_CNT_W'(5);
   endfunction
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[g] <= 1'b1;
            else        chain[g] <= d_i;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[g] <= 1'b1;
            else        chain[g] <= chain[g-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/urx_bit_timer.sv
module urx_bit_timer #(
   parameter int unsigned OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic tick_i,
   output logic mid_o,
   output logic full_o
);
   localparam int unsigned CW   = $clog2(OVS);
   localparam int unsigned HALF = OVS / 2;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)           cnt <= '0;
      else if (clear_i)     cnt <= '0;
      else if (tick_i)      cnt <= (cnt == CW'(OVS - 1)) ? '0 : cnt + 1'b1;

   assign mid_o  = tick_i && (cnt == CW'(HALF - 1));
   assign full_o = tick_i && (cnt == CW'(OVS - 1));
endmodule

// File: rtl/urx_parity.sv
module urx_parity (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic bit_vld_i,
   input  logic bit_i,
   input  logic odd_i,
   output logic err_o
);
   logic acc;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          acc <= 1'b0;
      else if (clear_i)    acc <= 1'b0;
      else if (bit_vld_i)  acc <= acc ^ bit_i;

   // bit_i carries the received parity bit when err_o is used
   assign err_o = acc ^ bit_i ^ odd_i;
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
   import urx_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       tick_i,
   input  logic       rxd_i,
   input  logic [2:0] size_i,
   input  logic       par_en_i,
   input  logic       par_odd_i,
   output logic       start_o,
   output logic       push_o,
   output logic [7:0] data_o,
   output logic       bit9_o,
   output logic       ferr_o,
   output logic       perr_o
);
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   urx_state_e                state;
   logic                      rx_s;
   logic                      mid_ev, full_ev, tmr_clear;
   logic [URX_CNT_W-1:0]      idx;
   logic [URX_CNT_W-1:0]      cfg_n_q;
   logic                      cfg_par_q, cfg_odd_q;
   logic [URX_MAX_BITS-1:0]   sh;
   logic                      perr_q;
   logic                      par_err;
   logic                      start_ok;

   urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rxd_i),
      .q_o   (rx_s)
   );

   assign start_ok  = (state == RX_START) && mid_ev && !rx_s;
   assign tmr_clear = (state == RX_IDLE) || (state == RX_HOLD) ||
                      ((state == RX_START) && mid_ev);

   urx_bit_timer #(.OVS(OVS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (tmr_clear),
      .tick_i  (tick_i),
      .mid_o   (mid_ev),
      .full_o  (full_ev)
   );

   urx_parity u_par (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (start_ok),
      .bit_vld_i ((state == RX_DATA) && full_ev),
      .bit_i     (rx_s),
      .odd_i     (cfg_odd_q),
      .err_o     (par_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         idx       <= '0;
         cfg_n_q   <= URX_CNT_W'(8);
         cfg_par_q <= 1'b0;
         cfg_odd_q <= 1'b0;
         sh        <= '0;
         perr_q    <= 1'b0;
         start_o   <= 1'b0;
         push_o    <= 1'b0;
         data_o    <= '0;
         bit9_o    <= 1'b0;
         ferr_o    <= 1'b0;
         perr_o    <= 1'b0;
      end else begin
         start_o <= 1'b0;
         push_o  <= 1'b0;
         if (!en_i) begin
            state <= RX_IDLE;
         end else begin
            unique case (state)
               RX_IDLE: begin
                  if (tick_i && !rx_s) begin
                     state     <= RX_START;
                     cfg_n_q   <= urx_len(size_i);
                     cfg_par_q <= par_en_i;
                     cfg_odd_q <= par_odd_i;
                  end
               end
               RX_START: begin
                  if (mid_ev) begin
                     if (!rx_s) begin
                        state   <= RX_DATA;
                        idx     <= '0;
                        sh      <= '0;
                        perr_q  <= 1'b0;
                        start_o <= 1'b1;
                     end else begin
                        state <= RX_IDLE;
                     end
                  end
               end
               RX_DATA: begin
                  if (full_ev) begin
                     sh[idx] <= rx_s;
                     if (idx == cfg_n_q - URX_CNT_W'(1))
                        state <= cfg_par_q ? RX_PAR : RX_STOP;
                     else
                        idx <= idx + URX_CNT_W'(1);
                  end
               end
               RX_PAR: begin
                  if (full_ev) begin
                     perr_q <= par_err;
                     state  <= RX_STOP;
                  end
               end
               RX_STOP: begin
                  if (full_ev) begin
                     push_o <= 1'b1;
                     data_o <= sh[7:0];
                     bit9_o <= sh[8];
                     ferr_o <= !rx_s;
                     perr_o <= cfg_par_q & perr_q;
                     state  <= rx_s ? RX_IDLE : RX_HOLD;
                  end
               end
               RX_HOLD: begin
                  if (rx_s) state <= RX_IDLE;
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/urx_rx_checker.sv
module urx_rx_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       en_i,
   input logic       start_o,
   input logic       push_o,
   input logic [7:0] data_o,
   input logic       bit9_o,
   input logic       perr_o,
   input logic       cfg_par,
   input logic [3:0] cfg_n
);
   a_r9_push_single: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |=> !push_o);

   a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);

   a_r11_no_push_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !push_o);

   a_r7_perr_off: assert property (@(posedge clk) disable iff (!rst_n)
      (push_o && !cfg_par) |-> !perr_o);

   a_r5_bit9_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (push_o && cfg_n != 4'd9) |-> !bit9_o);

   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (push_o && cfg_n == 4'd5) |-> (data_o[7:5] == 3'b000));

   a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !push_o |-> $stable(data_o));
endmodule

bind uart_rx_deframer urx_rx_checker u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en_i    (en_i),
   .start_o (start_o),
   .push_o  (push_o),
   .data_o  (data_o),
   .bit9_o  (bit9_o),
   .perr_o  (perr_o),
   .cfg_par (cfg_par_q),
   .cfg_n   (cfg_n_q)
);

// File: tb/test_uart_rx_deframer.sv
module test_uart_rx_deframer;
   localparam int BITCLK = 64; // 16 ticks x 4 clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_i = 1'b0;
   logic       tick_i = 1'b0;
   logic       rxd_i = 1'b1;
   logic [2:0] size_i = 3'd3;
   logic       par_en_i = 1'b0;
   logic       par_odd_i = 1'b0;
   logic       start_o, push_o, bit9_o, ferr_o, perr_o;
   logic [7:0] data_o;

   int checks = 0;
   int fails  = 0;
   int starts_seen = 0;
   int starts_exp  = 0;
   logic [1:0] tdiv = 2'd0;

   typedef struct packed {
      logic [7:0] data;
      logic       b9;
      logic       ferr;
      logic       perr;
   } exp_t;
   exp_t q[$];

   always #10 clk = ~clk; // 50 MHz

   uart_rx_deframer i_uart_rx_deframer (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick_i), .rxd_i(rxd_i),
      .size_i(size_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
      .start_o(start_o), .push_o(push_o), .data_o(data_o), .bit9_o(bit9_o),
      .ferr_o(ferr_o), .perr_o(perr_o)
   );

   always @(posedge clk) begin
      tdiv   <= tdiv + 2'd1;
      tick_i <= (tdiv == 2'd3);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: scoreboard pop and compare
   always @(negedge clk) begin
      if (start_o) starts_seen++;
      if (push_o) begin
         if (q.size() == 0) begin
            chk(1'b0, "R1/R11 unexpected push", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(data_o == e.data, "R3/R4 data", data_o, e.data);
            chk(bit9_o == e.b9, "R5 ninth bit", bit9_o, e.b9);
            chk(ferr_o == e.ferr, "R8 frame error", ferr_o, e.ferr);
            chk(perr_o == e.perr, "R6/R7 parity error", perr_o, e.perr);
         end
      end
   end

   task automatic line(input logic v);
      rxd_i = v;
      repeat (BITCLK) @(negedge clk);
   endtask

   // mode: 0 normal, 1 change settings after start, 2 abort after 3 data bits
   task automatic send(input logic [8:0] val, input int n, input bit pe, input bit odd,
                       input bit flip, input bit stop, input int extra_stop, input int mode);
      exp_t e;
      logic [8:0] m;
      logic p;
      m = (n >= 9) ? 9'h1FF : 9'((1 << n) - 1);
      size_i    = (n >= 9) ? 3'd4 : 3'(n - 5);
      par_en_i  = pe;
      par_odd_i = odd;
      p = (^(val & m)) ^ odd ^ flip;
      e.data = val[7:0] & m[7:0];
      e.b9   = (n >= 9) ? val[8] : 1'b0;
      e.ferr = !stop;
      e.perr = pe & flip;
      starts_exp++;
      if (mode != 2) q.push_back(e);
      line(1'b0);
      if (mode == 1) begin
         size_i = 3'(~size_i);
         par_en_i = !pe;
         par_odd_i = !odd;
      end
      for (int i = 0; i < n; i++) begin
         if (mode == 2 && i == 3) en_i = 1'b0;
         line(val[i]);
      end
      if (pe) line(p);
      line(stop);
      if (!stop) line(1'b1);
      for (int i = 0; i < extra_stop; i++) line(1'b1);
      if (mode == 2) begin
         line(1'b1);
         en_i = 1'b1;
         line(1'b1);
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk(push_o == 0 && start_o == 0 && data_o == 0 && ferr_o == 0 && perr_o == 0 && bit9_o == 0,
          "reset state", {push_o, start_o, ferr_o, perr_o, bit9_o}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1: enable low, line activity ignored
      send(9'h0AA, 8, 0, 0, 0, 1, 1, 2);
      starts_exp--; // enable was low from the start: no start expected
      en_i = 1'b1;
      line(1'b1);
      send(9'h0A5, 8, 0, 0, 0, 1, 1, 0);           // R3 8N1
      send(9'h0FF, 5, 0, 0, 0, 1, 1, 0);           // R3 R4 5-bit mask
      send(9'h0C6, 6, 0, 0, 0, 1, 1, 0);           // R4 6-bit
      send(9'h05A, 7, 0, 0, 0, 1, 1, 0);           // R4 7-bit
      send(9'h1C3, 9, 0, 0, 0, 1, 1, 0);           // R5 9-bit
      send(9'h0B7, 9, 0, 0, 0, 1, 1, 0);           // R5 ninth zero
      send(9'h03C, 8, 1, 0, 0, 1, 1, 0);           // R6 even ok
      send(9'h03D, 8, 1, 1, 0, 1, 1, 0);           // R6 odd ok
      send(9'h081, 8, 1, 0, 1, 1, 1, 0);           // R6 even bad
      send(9'h013, 7, 1, 1, 1, 1, 1, 0);           // R6 odd bad
      send(9'h066, 8, 0, 1, 0, 1, 1, 0);           // R7 parity off
      send(9'h0E1, 8, 0, 0, 0, 0, 1, 0);           // R8 stop low
      send(9'h011, 8, 0, 0, 0, 1, 0, 0);           // R9 one stop, back to back
      send(9'h122, 9, 1, 1, 0, 1, 0, 0);           // R9 back to back
      send(9'h047, 6, 0, 0, 0, 1, 1, 1);           // R10 settings changed mid frame
      send(9'h099, 8, 1, 0, 1, 1, 1, 1);           // R10 parity frame, settings changed
      // R1: glitch shorter than half a bit
      rxd_i = 1'b0;
      repeat (12) @(negedge clk);
      rxd_i = 1'b1;
      repeat (3 * BITCLK) @(negedge clk);
      chk(starts_seen == starts_exp, "R1 glitch rejected", starts_seen, starts_exp);
      send(9'h0F0, 8, 0, 0, 0, 1, 1, 2);           // R11 abort
      send(9'h00F, 8, 0, 0, 0, 1, 1, 0);           // recovery after abort
      repeat (2 * BITCLK) @(negedge clk);
      chk(starts_seen == starts_exp, "R2 start pulse count", starts_seen, starts_exp);
      chk(q.size() == 0, "R9/R11 all frames pushed", q.size(), 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule